// File: doc/BRIEF.md
# Multiplierless Transposed-Form Band-Pass FIR Filter

This block is a 32-tap linear-phase band-pass FIR filter built in transposed form, with no hardware multipliers. Each accepted input sample is scaled by all sixteen distinct coefficient values at once. Every constant product comes from a fixed network of shifted copies of the sample, which are added or subtracted according to the coefficient's canonical signed-digit (CSD) encoding. Because the coefficients are symmetric, each of the sixteen products feeds two positions of the transposed adder/register chain. The filter output is taken from the head adder of that chain.

A build option shares two common sub-terms, 3x and 5x, across all coefficients. When a coefficient has a pair of CSD digits two places apart, one shifted copy of a shared term replaces the two digits, so fewer adders are needed. A second option inserts pipeline registers after the product network. A third selects the output form: Q15 rounding with saturation to 16 bits, or the full 37-bit sum.

Samples arrive with a valid qualifier and may have gaps of any length between them. One output, also qualified, is produced for every accepted input.

Top module: `fir_bandpass_tf`

## Requirements
- R1: The unscaled filter sum for accepted sample n is y(n) = sum over k=0..31 of h[k]*x(n-k), computed bit-exact on 16-bit signed inputs. The coefficients are signed integers in Q15 with h[k] = h[31-k], and h[0..15] = -180, -448, 152, 840, 384, -1220, -1152, 1056, 2080, -272, -3052, -1072, 3396, 2824, -2560, -5680.
- R2: out_valid rises exactly 1+MULT_PIPE clock cycles after the edge that accepts a sample. There is exactly one output per accepted sample, and outputs come in input order.
- R3: While in_valid is low, in_data is ignored and the chain registers do not change. While out_valid is low, out_data keeps its last value.
- R4: A synchronous active-high reset clears out_valid, out_data and every chain register to zero. The outputs that follow a reset are computed as if all earlier inputs were zero.
- R5: Each constant product is formed only from shifted, added or subtracted copies of the sample (CSD digits in {-1,0,+1}, no two adjacent digits nonzero), and it equals x*h[k] exactly. The shared terms equal 3x and 5x.
- R6: With ROUND_OUT=1 the 16-bit output is floor((y + 2^14) / 2^15), saturated to the range [-32768, 32767].
- R7: With ROUND_OUT=0 the output is the 37-bit two's complement value y with no scaling.
- R8: With SHARE_TERMS=1, which uses the shared 3x/5x terms for CSD digit pairs two places apart, the filter gives exactly the same outputs as the plain CSD network.
- R9: Each of the sixteen products drives chain positions k and 31-k. An impulse of amplitude A therefore produces the 32-output response A*h[0..31], which is symmetric about its midpoint.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_data; the chain advances only on accepted samples |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Registered; high for one cycle per filter output |
| out_data | output | OUT_W | Signed output, rounded to 16 bits or full width |

## Verification
The embedded properties check the following on every cycle. Each shift-add product must match the true product, and the shared 3x and 5x terms must hold their values. The chain must not change between accepted samples, and the output must hold between valid outputs. The reset state is checked, as is the one-cycle valid latency of the unpipelined build. A rounded output must stay within half an LSB of the full sum unless it is at a saturation limit. Only the bench scenarios can show that the whole chain computes the right convolution. The bench runs an impulse, a step, full-scale alternation, patterns matched to the coefficient signs that drive both saturation limits, a reset in mid-stream, and long random runs with random gaps. A rounded build and a full-width build with shared terms and two pipeline stages are compared against the same arithmetic model.

// File: rtl/fir_bp_pkg.sv
package fir_bp_pkg;

  localparam int NUNIQ = 16;
  localparam int TAPS  = 2 * NUNIQ;

  // Q15 integer coefficients for positions 0..15; positions 16..31 mirror them.
  function automatic int coef(input int idx);
    case (idx)
      0:  return -180;
      1:  return -448;
      2:  return 152;
      3:  return 840;
      4:  return 384;
      5:  return -1220;
      6:  return -1152;
      7:  return 1056;
      8:  return 2080;
      9:  return -272;
      10: return -3052;
      11: return -1072;
      12: return 3396;
      13: return 2824;
      14: return -2560;
      15: return -5680;
      default: return 0;
    endcase
  endfunction

  // Which unique product feeds chain position k.
  function automatic int mirror_idx(input int k);
    return (k < NUNIQ) ? k : (TAPS - 1 - k);
  endfunction

  // Signed digit at weight 2^b of the non-adjacent (canonical) form of c.
  function automatic int csd_digit(input int c, input int b);
    int v;
    int d;
    int res;
    v   = c;
    res = 0;
    for (int i = 0; i < 40; i++) begin
      if (i <= b) begin
        if ((v & 1) == 0)      d = 0;
        else if ((v & 3) == 1) d = 1;
        else                   d = -1;
        if (i == b) res = d;
        v = (v - d) >>> 1;
      end
    end
    return res;
  endfunction

  // Term kind at weight 2^b once digit pairs two apart are folded into shared
  // 5x (equal signs) or 3x (opposite signs) terms, scanning from the LSB.
  // Returns 0, +-1 (plain x), +-3 or +-5.
  function automatic int share_kind(input int c, input int b);
    logic [47:0] used;
    int res;
    int di;
    int dj;
    int k;
    used = '0;
    res  = 0;
    for (int i = 0; i < 40; i++) begin
      if (i <= b) begin
        k  = 0;
        di = csd_digit(c, i);
        if (!used[i] && di != 0) begin
          dj = csd_digit(c, i + 2);
          if (dj == di) begin
            k = 5 * di;
            used[i+2] = 1'b1;
          end else if (dj == -di) begin
            k = -3 * di;
            used[i+2] = 1'b1;
          end else begin
            k = di;
          end
        end
        if (i == b) res = k;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/fir_csd_mult.sv
module fir_csd_mult #(
  parameter int DATA_W = 16,
  parameter int PROD_W = 32,
  parameter int NB     = 17,
  parameter int COEF   = 1,
  parameter int SHARE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] x,
  input  logic [PROD_W-1:0] x3,
  input  logic [PROD_W-1:0] x5,
  output logic [PROD_W-1:0] p
);

  logic [PROD_W-1:0]         xe;
  logic [NB-1:0][PROD_W-1:0] term;

  assign xe = PROD_W'($signed(x));

  for (genvar b = 0; b < NB; b++) begin : g_digit
    localparam int K = (SHARE != 0) ? fir_bp_pkg::share_kind(COEF, b)
                                    : fir_bp_pkg::csd_digit(COEF, b);
    if (K == 1) begin : g_pos
      assign term[b] = xe << b;
    end else if (K == -1) begin : g_neg
      assign term[b] = -(xe << b);
    end else if (K == 3) begin : g_pos3
      assign term[b] = x3 << b;
    end else if (K == -3) begin : g_neg3
      assign term[b] = -(x3 << b);
    end else if (K == 5) begin : g_pos5
      assign term[b] = x5 << b;
    end else if (K == -5) begin : g_neg5
      assign term[b] = -(x5 << b);
    end else begin : g_zero
      assign term[b] = '0;
    end
  end

  // Adder network over the nonzero terms; wrap-around is harmless because
  // the exact product fits PROD_W.
  always_comb begin
    p = '0;
    for (int b = 0; b < NB; b++) p = p + term[b];
  end

  AST_CSD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    p == PROD_W'(longint'($signed(x)) * longint'(COEF))); // R5
  AST_SHARED_TERMS: assert property (@(posedge clk) disable iff (rst)
    (x3 == PROD_W'(3 * longint'($signed(x)))) &&
    (x5 == PROD_W'(5 * longint'($signed(x))))); // R5

endmodule

// File: rtl/fir_mult_bank.sv
module fir_mult_bank #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int SHARE  = 0,
  parameter int PIPE   = 0
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         x_valid,
  input  logic [DATA_W-1:0]                            x,
  output logic                                         prod_valid,
  output logic [fir_bp_pkg::NUNIQ-1:0][DATA_W+COEF_W-1:0] prod
);

  localparam int NUNIQ  = fir_bp_pkg::NUNIQ;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int NB     = COEF_W + 1;

  logic [PROD_W-1:0]             xe;
  logic [PROD_W-1:0]             x3;
  logic [PROD_W-1:0]             x5;
  logic [NUNIQ-1:0][PROD_W-1:0]  raw;

  // Shared sub-terms, built once for all coefficients.
  assign xe = PROD_W'($signed(x));
  assign x3 = (xe << 1) + xe;
  assign x5 = (xe << 2) + xe;

  for (genvar i = 0; i < NUNIQ; i++) begin : g_mult
    fir_csd_mult #(
      .DATA_W (DATA_W),
      .PROD_W (PROD_W),
      .NB     (NB),
      .COEF   (fir_bp_pkg::coef(i)),
      .SHARE  (SHARE)
    ) u_mult (
      .clk (clk),
      .rst (rst),
      .x   (x),
      .x3  (x3),
      .x5  (x5),
      .p   (raw[i])
    );
  end

  if (PIPE == 0) begin : g_nopipe
    assign prod       = raw;
    assign prod_valid = x_valid;
  end else begin : g_pipe
    logic [PIPE-1:0][NUNIQ-1:0][PROD_W-1:0] stg;
    logic [PIPE-1:0]                        vstg;
    always_ff @(posedge clk) begin
      stg[0] <= raw;
      for (int s = 1; s < PIPE; s++) stg[s] <= stg[s-1];
      if (rst) begin
        vstg <= '0;
      end else begin
        vstg <= {vstg[PIPE-1:0] << 1} | PIPE'(x_valid);
      end
    end
    assign prod       = stg[PIPE-1];
    assign prod_valid = vstg[PIPE-1];
  end

endmodule

// File: rtl/fir_tap_chain.sv
module fir_tap_chain #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 37
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    en,
  input  logic [fir_bp_pkg::NUNIQ-1:0][PROD_W-1:0] prod,
  output logic [ACC_W-1:0]                        sum0
);

  localparam int TAPS = fir_bp_pkg::TAPS;

  logic [TAPS-1:1][ACC_W-1:0]       acc;
  logic [fir_bp_pkg::NUNIQ-1:0][ACC_W-1:0] pe;

  for (genvar i = 0; i < fir_bp_pkg::NUNIQ; i++) begin : g_ext
    assign pe[i] = ACC_W'($signed(prod[i]));
  end

  // Transposed chain: position k adds its product onto position k+1.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      for (int k = 1; k < TAPS - 1; k++)
        acc[k] <= pe[fir_bp_pkg::mirror_idx(k)] + acc[k+1];
      acc[TAPS-1] <= pe[fir_bp_pkg::mirror_idx(TAPS-1)];
    end
  end

  assign sum0 = pe[0] + acc[1];

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc)); // R3

endmodule

// File: rtl/fir_out_scale.sv
module fir_out_scale #(
  parameter int ACC_W = 37,
  parameter int OUT_W = 16,
  parameter int FRAC  = 15,
  parameter int ROUND = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] sum,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  logic [OUT_W-1:0] nxt;

  if (ROUND != 0) begin : g_round
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] shf;
    assign rnd = $signed(sum) + HALF;
    assign shf = rnd >>> FRAC;
    always_comb begin
      if (shf > MAXV)      nxt = MAXV[OUT_W-1:0];
      else if (shf < MINV) nxt = MINV[OUT_W-1:0];
      else                 nxt = shf[OUT_W-1:0];
    end

    AST_ROUND_ERROR: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_data != MAXV[OUT_W-1:0]) && (out_data != MINV[OUT_W-1:0]) |->
      ((longint'($signed($past(sum))) - longint'($signed(out_data)) * (longint'(1) << FRAC))
         >= -(longint'(1) << (FRAC - 1))) &&
      ((longint'($signed($past(sum))) - longint'($signed(out_data)) * (longint'(1) << FRAC))
         <  (longint'(1) << (FRAC - 1)))); // R6
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_data == MAXV[OUT_W-1:0]) |->
      longint'($signed($past(sum))) >= longint'(MAXV) * (longint'(1) << FRAC) - (longint'(1) << (FRAC - 1))); // R6
  end else begin : g_full
    assign nxt = OUT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= en;
      if (en) out_data <= nxt;
    end
  end

endmodule

// File: rtl/fir_bandpass_tf.sv
module fir_bandpass_tf #(
  parameter int DATA_W      = 16,
  parameter int COEF_W      = 16,
  parameter int GUARD       = 5,
  parameter int FRAC        = 15,
  parameter int ROUND_OUT   = 1,
  parameter int SHARE_TERMS = 0,
  parameter int MULT_PIPE   = 0,
  parameter int OUT_W       = (ROUND_OUT != 0) ? DATA_W : DATA_W + COEF_W + GUARD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + GUARD;

  logic                                    prod_valid;
  logic [fir_bp_pkg::NUNIQ-1:0][PROD_W-1:0] prod;
  logic [ACC_W-1:0]                        sum0;

  fir_mult_bank #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .SHARE  (SHARE_TERMS),
    .PIPE   (MULT_PIPE)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .x_valid    (in_valid),
    .x          (in_data),
    .prod_valid (prod_valid),
    .prod       (prod)
  );

  fir_tap_chain #(
    .PROD_W (PROD_W),
    .ACC_W  (ACC_W)
  ) u_chain (
    .clk  (clk),
    .rst  (rst),
    .en   (prod_valid),
    .prod (prod),
    .sum0 (sum0)
  );

  fir_out_scale #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .FRAC  (FRAC),
    .ROUND (ROUND_OUT)
  ) u_scale (
    .clk       (clk),
    .rst       (rst),
    .en        (prod_valid),
    .sum       (sum0),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && (out_data == '0))); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R3

  if (MULT_PIPE == 0) begin : g_lat_chk
    AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R2
  end

endmodule

// File: tb/fir_bandpass_tf_bench.sv
module fir_bandpass_tf_bench;

  localparam int FULL_W = 37;
  localparam int PIPE2  = 2;
  localparam int MAXN   = 2048;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [15:0]       in_data = '0;
  logic              ov1;
  logic [15:0]       od1;
  logic              ov2;
  logic [FULL_W-1:0] od2;

  always #2 clk = ~clk;

  fir_bandpass_tf u_fir_bandpass_tf (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .out_valid (ov1), .out_data (od1)
  );

  fir_bandpass_tf #(
    .ROUND_OUT (0), .SHARE_TERMS (1), .MULT_PIPE (PIPE2), .OUT_W (FULL_W)
  ) u_fir_full (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .out_valid (ov2), .out_data (od2)
  );

  int     nchk = 0;
  int     nerr = 0;
  int     cyc  = 0;
  int     wr   = 0;
  int     rd1  = 0;
  int     rd2  = 0;
  bit     done = 1'b0;
  string  ptag = "R1";
  longint hist [32];
  longint exp_r [MAXN];
  longint exp_f [MAXN];
  int     acc_cyc [MAXN];
  longint last1 = 0;
  longint last2 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint bh(input int k);
    int i;
    i = (k < 16) ? k : 31 - k;
    case (i)
      0: return -180;   1: return -448;   2: return 152;    3: return 840;
      4: return 384;    5: return -1220;  6: return -1152;  7: return 1056;
      8: return 2080;   9: return -272;   10: return -3052; 11: return -1072;
      12: return 3396;  13: return 2824;  14: return -2560; default: return -5680;
    endcase
  endfunction

  task automatic check(input string req, input longint got, input longint expv);
    nchk++;
    if (got != expv) begin
      nerr++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, expv);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < 32; k++) hist[k] = 0;
  endtask

  // Model: direct convolution, then Q15 round-half-up with saturation.
  task automatic send(input int x, input int gap);
    longint conv;
    longint r;
    for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(x);
    conv = 0;
    for (int k = 0; k < 32; k++) conv += bh(k) * hist[k];
    r = (conv + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    exp_f[wr]   = conv;
    exp_r[wr]   = r;
    acc_cyc[wr] = cyc + 1;
    wr++;
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_data = 16'($urandom);
      @(negedge clk);
    end
  endtask

  // Output monitors, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst) begin
      last1 = 0;
      last2 = 0;
    end else if (!done) begin
      if (ov1) begin
        check({ptag, " R6 data"}, longint'($signed(od1)), exp_r[rd1]);
        check("R2 latency rounded", longint'(cyc), longint'(acc_cyc[rd1]));
        last1 = longint'($signed(od1));
        rd1++;
      end else begin
        check("R3 hold rounded", longint'($signed(od1)), last1);
      end
      if (ov2) begin
        check({ptag, " R7 R8 data"}, longint'($signed(od2)), exp_f[rd2]);
        check("R2 latency pipelined", longint'(cyc), longint'(acc_cyc[rd2] + PIPE2));
        last2 = longint'($signed(od2));
        rd2++;
      end else begin
        check("R3 hold full", longint'($signed(od2)), last2);
      end
    end
  end

  task automatic check_reset_state();
    check("R4 valid rounded", longint'(ov1), 0);
    check("R4 data rounded", longint'($signed(od1)), 0);
    check("R4 valid full", longint'(ov2), 0);
    check("R4 data full", longint'($signed(od2)), 0);
  endtask

  initial begin
    clear_hist();
    repeat (4) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);

    // R9: impulse response mirrors the coefficient set.
    ptag = "R9";
    send(32767, 0);
    for (int i = 0; i < 34; i++) send(0, 0);

    ptag = "R1 step";
    for (int i = 0; i < 40; i++) send(20000, i % 2);

    ptag = "R1 alternating";
    for (int i = 0; i < 40; i++) send((i % 2) ? -32768 : 32767, 0);

    // Sign-matched full-scale inputs push the rounded output into both limits.
    ptag = "R6 saturate";
    for (int m = 0; m < 32; m++) send((bh(m) >= 0) ? 32767 : -32768, 0);
    for (int m = 0; m < 32; m++) send((bh(m) >= 0) ? -32768 : 32767, 0);

    // R4: reset in mid-stream, history restarts from zero.
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    clear_hist();
    rst = 1'b0;
    @(negedge clk);
    ptag = "R4 after reset";
    for (int i = 0; i < 20; i++) send(1000 * (i + 1), 0);

    // R3 and R5: random samples with random gaps and garbage between them.
    ptag = "R5 random";
    for (int i = 0; i < 600; i++) send(int'($signed(16'($urandom))), int'($urandom % 3));

    ptag = "R1 flush";
    for (int i = 0; i < 32; i++) send(0, 0);
    repeat (8) @(negedge clk);

    check("R2 count rounded", longint'(rd1), longint'(wr));
    check("R2 count full", longint'(rd2), longint'(wr));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL R2 watchdog expired: got %0d outputs expected %0d", rd1, wr);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

endmodule